// File: doc/BRIEF.md
# Dual-Write Register File

A 32-entry, 32-bit register file with two combinational read ports and two independently enabled synchronous write ports. It serves a datapath where one instruction both loads a value into a destination register and writes back an incremented base address into the base register during the same clock edge. Read port A supplies the base operand; an adder outside this block adds the step and returns the result on write port B.

Both write ports capture on the rising clock edge. Register 0 is hardwired to zero. When both ports write the same nonzero register on one edge, port B takes precedence. Reads return the stored array contents with no forwarding of data being written on the same edge. A synchronous reset clears every entry.

Top module: `dual_wr_regfile`

## Requirements
- R1: While rst is high at a rising edge, every register is cleared, so both read ports return 0 afterwards for any address.
- R2: With wa_en high, wa_data is stored at wa_addr on the rising edge and appears on a read port addressing wa_addr after that edge.
- R3: With wb_en high, wb_data is stored at wb_addr on the rising edge and is then visible on the read ports.
- R4: wa_en and wb_en are independent; with both high and different addresses, both registers are updated on the same edge.
- R5: When both enables are high and wa_addr equals wb_addr (nonzero), the register takes wb_data.
- R6: Address 0 reads as 0 on both read ports, and writes to address 0 through either port leave it 0.
- R7: A write port whose enable is low changes no register.
- R8: Read ports are combinational from the stored array; a write on an edge is not visible before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ra_addr | input | 5 | Read port A address |
| ra_data | output | 32 | Read port A data |
| rb_addr | input | 5 | Read port B address |
| rb_data | output | 32 | Read port B data |
| wa_en | input | 1 | Write port A enable |
| wa_addr | input | 5 | Write port A address |
| wa_data | input | 32 | Write port A data |
| wb_en | input | 1 | Write port B enable |
| wb_addr | input | 5 | Write port B address |
| wb_data | input | 32 | Write port B data |

## Verification
A wrong stored value, a write dropped by one port, or the wrong winner in a same-register collision shows on a read port as soon as that register is addressed. The register is visible in the cycle following the faulty edge. Because the reads are combinational, the bench sweeps both read addresses every cycle. A model mismatch is therefore caught within a cycle of the write whenever the affected entry is read. Writes aimed at register 0 are checked by reading address 0 immediately after the edge.

// File: rtl/dual_wr_regfile.sv
module dual_wr_regfile #(
  parameter int DW = 32,
  parameter int NREG = 32,
  localparam int AW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra_addr,
  output logic [DW-1:0] ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [DW-1:0] rb_data,
  input  logic          wa_en,
  input  logic [AW-1:0] wa_addr,
  input  logic [DW-1:0] wa_data,
  input  logic          wb_en,
  input  logic [AW-1:0] wb_addr,
  input  logic [DW-1:0] wb_data
);
  logic [DW-1:0] regs [NREG];

  for (genvar i = 1; i < NREG; i++) begin : g_reg
    wire hit_a = wa_en && (wa_addr == AW'(i));
    wire hit_b = wb_en && (wb_addr == AW'(i));
    always_ff @(posedge clk) begin
      if (rst)        regs[i] <= '0;
      else if (hit_b) regs[i] <= wb_data;
      else if (hit_a) regs[i] <= wa_data;
    end
  end

  assign regs[0] = '0;
  assign ra_data = regs[ra_addr];
  assign rb_data = regs[rb_addr];
endmodule

module dual_wr_regfile_chk #(
  parameter int DW = 32,
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] ra_addr,
  input logic [DW-1:0] ra_data,
  input logic [AW-1:0] rb_addr,
  input logic [DW-1:0] rb_data,
  input logic          wa_en,
  input logic [AW-1:0] wa_addr,
  input logic [DW-1:0] wa_data,
  input logic          wb_en,
  input logic [AW-1:0] wb_addr,
  input logic [DW-1:0] wb_data
);
  logic live;
  always_ff @(posedge clk) live <= !rst;

  AST_ZERO_RA: assert property (@(posedge clk) disable iff (rst) (ra_addr == '0) |-> (ra_data == '0)); // R6
  AST_ZERO_RB: assert property (@(posedge clk) disable iff (rst) (rb_addr == '0) |-> (rb_data == '0)); // R6
  AST_PORT_B_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wb_en && wb_addr != '0 && $stable(ra_addr)) ##1 (ra_addr == $past(wb_addr)) |-> (ra_data == $past(wb_data))); // R3
  AST_PORT_A_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wa_en && wa_addr != '0 && !(wb_en && wb_addr == wa_addr)) ##1 (rb_addr == $past(wa_addr)) |-> (rb_data == $past(wa_data))); // R2
  AST_RESET_CLEARS: assert property (@(posedge clk) (live == 1'b0 && $past(rst)) |-> (ra_data == '0 && rb_data == '0)); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (live && !wa_en && !wb_en && $stable(ra_addr)) |=> (ra_data == $past(ra_data) || ra_addr != $past(ra_addr))); // R7
endmodule

bind dual_wr_regfile dual_wr_regfile_chk #(.DW(DW), .AW(AW)) u_chk (.*);

// File: tb/sim_dual_wr_regfile.sv
module sim_dual_wr_regfile;
  logic clk = 0, rst = 1;
  logic [4:0] ra_addr = 0, rb_addr = 0, wa_addr = 0, wb_addr = 0;
  logic [31:0] wa_data = 0, wb_data = 0, ra_data, rb_data;
  logic wa_en = 0, wb_en = 0;
  int tests = 0, fails = 0;
  logic [31:0] model [32];

  always #10 clk = ~clk;

  dual_wr_regfile u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic edge_step();
    @(posedge clk);
    if (rst) foreach (model[i]) model[i] = 0;
    else begin
      if (wa_en && wa_addr != 0) model[wa_addr] = wa_data;
      if (wb_en && wb_addr != 0) model[wb_addr] = wb_data;
    end
    #2;
  endtask

  task automatic sweep(input string req);
    for (int a = 0; a < 32; a++) begin
      ra_addr = 5'(a); rb_addr = 5'(31 - a); #1;
      chk(req, ra_data, model[a]);
      chk(req, rb_data, model[31 - a]);
    end
  endtask

  task automatic wr(input logic ea, input logic [4:0] aa, input logic [31:0] da,
                    input logic eb, input logic [4:0] ab, input logic [31:0] db);
    @(negedge clk);
    wa_en = ea; wa_addr = aa; wa_data = da;
    wb_en = eb; wb_addr = ab; wb_data = db;
  endtask

  initial begin
    #200000;
    fails++; tests++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    foreach (model[i]) model[i] = 'x;
    @(negedge clk); edge_step(); edge_step();
    @(negedge clk); rst = 0;
    sweep("R1");

    wr(1, 5, 32'hAAAA0005, 0, 0, 0);
    #1; ra_addr = 5; #1; chk("R8", ra_data, 32'h0);
    edge_step(); sweep("R2");

    wr(0, 0, 0, 1, 9, 32'hBBBB0009);
    edge_step(); sweep("R3");

    wr(1, 3, 32'h11110003, 1, 4, 32'h22220004);
    edge_step(); sweep("R4");
    ra_addr = 3; rb_addr = 4; #1;
    chk("R4", ra_data, 32'h11110003); chk("R4", rb_data, 32'h22220004);

    wr(1, 7, 32'hDEAD0007, 1, 7, 32'hBEEF0007);
    edge_step(); ra_addr = 7; #1; chk("R5", ra_data, 32'hBEEF0007);
    sweep("R5");

    wr(1, 0, 32'hFFFFFFFF, 1, 0, 32'h12345678);
    edge_step(); ra_addr = 0; rb_addr = 0; #1;
    chk("R6", ra_data, 0); chk("R6", rb_data, 0);

    wr(0, 5, 32'h55555555, 0, 9, 32'h66666666);
    edge_step(); edge_step(); sweep("R7");

    for (int k = 0; k < 40; k++) begin
      wr(k % 3 != 0, 5'(k * 7), 32'(k * 32'h01010101),
         k % 2 == 0, 5'(k * 11 + 1), 32'(~(k * 32'h00100011)));
      edge_step();
      ra_addr = 5'(k * 7); rb_addr = 5'(k * 11 + 1); #1;
      chk("R2", ra_data, model[5'(k * 7)]);
      chk("R3", rb_data, model[5'(k * 11 + 1)]);
    end
    wr(0, 0, 0, 0, 0, 0);
    sweep("R7");

    @(negedge clk); rst = 1; edge_step();
    @(negedge clk); rst = 0;
    sweep("R1");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule